// File: doc/BRIEF.md
# Sequenced Command Parameter Collector

This block is a write-only command port on a 32-bit register bus. Software writes the four pointers of one conversion command, one after another, to a single command address. The block tells them apart only by their position in the sequence: first the luma (Y) input plane pointer, then the U plane pointer, then the V plane pointer, and last the output buffer pointer. The fourth write completes the command. All four pointers then go together into a small first-in first-out command queue.

A block-enable input gates the port. While it is low, writes are thrown away and the partly gathered command is abandoned, so the next accepted write is again a Y pointer. The queue hands out commands through a valid/ready handshake. If a command is completed while the queue is full, that command is dropped and a sticky overflow flag is raised. Reads of the port return zero, because it keeps no readable copy of what was written.

Top module: `cmd_param_collector`

## Requirements
- R1: Accepted writes are taken in order as Y, U, V and output pointer. On the fourth accepted write, one entry holding all four pointers is queued in the same cycle, and it appears on cmd_y, cmd_u, cmd_v and cmd_out.
- R2: No entry is queued until all four parameters have been accepted; after one, two or three accepted writes cmd_valid stays low.
- R3: rdata is 0 at all times, whatever has been written.
- R4: A write while en is 0 is discarded. It neither queues anything nor counts toward the four-write sequence.
- R5: While en is 0 the sequence position returns to the start, so a partly written command is abandoned and the next accepted write is taken as the Y pointer.
- R6: The queue holds up to DEPTH (default 4) commands and delivers them oldest first. An entry is removed only on a clock edge where cmd_valid and cmd_ready are both 1, and the head stays unchanged while it waits.
- R7: A fourth write that arrives while the queue holds DEPTH entries is dropped, the queue contents stay as they were, and overflow is set to 1 and stays at 1 until reset. The position in the sequence still returns to the start.
- R8: Writes to any address other than CMD_ADDR (default 0x40) have no effect.
- R9: A synchronous active-high reset empties the queue, clears overflow and returns the sequence to the Y position.

Note on R7: "holds DEPTH entries" refers to the count before any removal on the same edge. A completing write is dropped even if an entry leaves in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; writes are accepted only when 1 |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, always 0 |
| cmd_valid | output | 1 | Queue head holds a command |
| cmd_ready | input | 1 | Consumer takes the head command |
| cmd_y | output | 32 | Head command Y plane pointer |
| cmd_u | output | 32 | Head command U plane pointer |
| cmd_v | output | 32 | Head command V plane pointer |
| cmd_out | output | 32 | Head command output pointer |
| overflow | output | 1 | Sticky flag: a completed command was dropped |

## Verification
The main function is tried with several kinds of write sequence:
- Four clean writes with distinct values. Swapped or shifted parameter slots show up here.
- Sequences cut short after one to three writes, which expose early pushes.
- Writes interleaved with disabled cycles and foreign addresses. These tell discarding apart from counting.
- A drop of the enable in the middle of a command, which separates abandonment from resumption.

A burst that fills the queue beyond four, drained with a ready pattern that stalls and resumes, checks the ordering, the head-hold behaviour and the drop-on-full rule. A pop in the same cycle as the completing write shows which count the full test uses.

// File: rtl/cmd_param_collector.sv
module cmd_param_collector #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] CMD_ADDR = 8'h40,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [DW-1:0] cmd_y,
  output logic [DW-1:0] cmd_u,
  output logic [DW-1:0] cmd_v,
  output logic [DW-1:0] cmd_out,
  output logic          overflow
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = 4 * DW;

  logic [1:0]    phase;
  logic [DW-1:0] hold_y, hold_u, hold_v;
  logic [EW-1:0] mem [DEPTH];
  logic [IW-1:0] wp, rp;
  logic [CW-1:0] count;

  logic wr_hit, last, full, push, pop;

  assign wr_hit    = wr_en && en && (addr == CMD_ADDR);
  assign last      = wr_hit && (phase == 2'd3);
  assign full      = (count == CW'(DEPTH));
  assign push      = last && !full;
  assign cmd_valid = (count != '0);
  assign pop       = cmd_valid && cmd_ready;
  assign rdata     = '0;

  assign cmd_y   = mem[rp][EW-1 -: DW];
  assign cmd_u   = mem[rp][EW-DW-1 -: DW];
  assign cmd_v   = mem[rp][EW-2*DW-1 -: DW];
  assign cmd_out = mem[rp][DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= 2'd0;
      hold_y   <= '0;
      hold_u   <= '0;
      hold_v   <= '0;
      wp       <= '0;
      rp       <= '0;
      count    <= '0;
      overflow <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (!en) phase <= 2'd0;
      else if (wr_hit) begin
        phase <= phase + 2'd1;
        case (phase)
          2'd0: hold_y <= wdata;
          2'd1: hold_u <= wdata;
          2'd2: hold_v <= wdata;
          default: ;
        endcase
      end
      if (push) begin
        mem[wp] <= {hold_y, hold_u, hold_v, wdata};
        wp <= (wp == IW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == IW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
      if (last && full) overflow <= 1'b1;
    end
  end
endmodule

module cmd_param_collector_chk #(
  parameter int DW = 32,
  parameter int DEPTH = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [1:0]    phase,
  input logic [CW-1:0] count,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [DW-1:0] cmd_y,
  input logic [DW-1:0] cmd_u,
  input logic [DW-1:0] cmd_v,
  input logic [DW-1:0] cmd_out,
  input logic          overflow
);
  p_depth_bound_r6: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  p_head_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable({cmd_y, cmd_u, cmd_v, cmd_out})));

  p_sticky_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  p_full_no_grow_r7: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(DEPTH) && !cmd_ready) |=> (count == $past(count)));

  p_disabled_no_push_r4: assert property (@(posedge clk) disable iff (rst)
    (!en && !(cmd_valid && cmd_ready)) |=> (count == $past(count)));

  p_disable_restart_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> (phase == 2'd0));
endmodule

bind cmd_param_collector cmd_param_collector_chk #(
  .DW(DW), .DEPTH(DEPTH), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .phase(phase), .count(count),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_y(cmd_y),
  .cmd_u(cmd_u), .cmd_v(cmd_v), .cmd_out(cmd_out), .overflow(overflow)
);

// File: tb/cmd_param_collector_bench.sv
module cmd_param_collector_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CA = 8'h40;

  logic clk = 0, rst = 1, en = 0, wr_en = 0, cmd_ready = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata, cmd_y, cmd_u, cmd_v, cmd_out;
  logic cmd_valid, overflow;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_param_collector u_cmd_param_collector (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_y(cmd_y), .cmd_u(cmd_u), .cmd_v(cmd_v), .cmd_out(cmd_out),
    .overflow(overflow)
  );

  int tests = 0, fails = 0, cyc = 0;
  string tag = "R9";

  logic [127:0] q[$];
  logic [31:0] h[3];
  int ph = 0;
  bit m_ov = 0;

  always @(posedge clk) begin
    bit do_push, do_pop;
    cyc++;
    do_push = 0;
    do_pop = 0;
    if (rst) begin
      q.delete(); ph = 0; m_ov = 0;
    end else begin
      do_pop = cmd_ready && q.size() > 0;
      if (!en) ph = 0;
      else if (wr_en && addr == CA) begin
        if (ph < 3) h[ph] = wdata;
        else if (q.size() >= 4) m_ov = 1;
        else do_push = 1;
        ph = (ph + 1) % 4;
      end
      if (do_pop) void'(q.pop_front());
      if (do_push) q.push_back({h[0], h[1], h[2], wdata});
    end
  end

  task automatic chk(string t, bit ok, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", t, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    chk({tag, " valid"}, cmd_valid == (q.size() > 0), 128'(cmd_valid), 128'(q.size() > 0));
    if (q.size() > 0)
      chk({tag, " data"}, {cmd_y, cmd_u, cmd_v, cmd_out} == q[0],
          {cmd_y, cmd_u, cmd_v, cmd_out}, q[0]);
    chk({tag, " overflow"}, overflow == m_ov, 128'(overflow), 128'(m_ov));
    chk("R3 rdata", rdata == 0, 128'(rdata), 128'(0));
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    tick();
    wr_en = 0;
  endtask

  task automatic cmd(logic [31:0] base);
    for (int i = 0; i < 4; i++) wr(CA, base + 32'(i));
  endtask

  always @(posedge clk) if (cyc > 20000) begin
    fails++;
    $display("FAIL watchdog act=%0d exp<20000", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    tag = "R9";
    chk("R9 reset valid", cmd_valid == 0, 128'(cmd_valid), 0);
    chk("R9 reset overflow", overflow == 0, 128'(overflow), 0);
    rst = 0; en = 1;
    tick();

    tag = "R1";
    cmd(32'h1000_0000);
    chk("R1 order", {cmd_y, cmd_u, cmd_v, cmd_out} ==
        {32'h1000_0000, 32'h1000_0001, 32'h1000_0002, 32'h1000_0003},
        {cmd_y, cmd_u, cmd_v, cmd_out},
        {32'h1000_0000, 32'h1000_0001, 32'h1000_0002, 32'h1000_0003});
    cmd_ready = 1; tick(); cmd_ready = 0;

    tag = "R2";
    for (int i = 0; i < 3; i++) begin
      wr(CA, 32'hA0 + 32'(i));
      chk("R2 partial", cmd_valid == 0, 128'(cmd_valid), 0);
    end
    wr(CA, 32'hA3);
    chk("R2 complete", cmd_valid == 1, 128'(cmd_valid), 1);
    cmd_ready = 1; tick(); cmd_ready = 0;

    tag = "R4";
    wr(CA, 32'hB0); wr(CA, 32'hB1);
    en = 0;
    for (int i = 0; i < 6; i++) wr(CA, 32'hDEAD0000 + 32'(i));
    chk("R4 disabled", cmd_valid == 0, 128'(cmd_valid), 0);

    tag = "R5";
    en = 1;
    wr(CA, 32'hC0); wr(CA, 32'hC1); wr(CA, 32'hC2);
    chk("R5 restart", cmd_valid == 0, 128'(cmd_valid), 0);
    wr(CA, 32'hC3);
    chk("R5 y slot", cmd_y == 32'hC0, 128'(cmd_y), 128'(32'hC0));
    cmd_ready = 1; tick(); cmd_ready = 0;

    tag = "R8";
    wr(CA, 32'hE0); wr(8'h44, 32'hFF); wr(CA, 32'hE1); wr(8'h00, 32'hFE);
    wr(CA, 32'hE2);
    chk("R8 foreign", cmd_valid == 0, 128'(cmd_valid), 0);
    wr(CA, 32'hE3);
    chk("R8 out slot", cmd_out == 32'hE3, 128'(cmd_out), 128'(32'hE3));
    cmd_ready = 1; tick(); cmd_ready = 0;

    tag = "R6";
    for (int k = 0; k < 4; k++) cmd(32'h2000_0000 + 32'(k << 8));
    tag = "R7";
    cmd(32'h3000_0000);
    chk("R7 overflow set", overflow == 1, 128'(overflow), 1);
    chk("R7 head kept", cmd_y == 32'h2000_0000, 128'(cmd_y), 128'(32'h2000_0000));
    wr(CA, 32'h31); wr(CA, 32'h32); wr(CA, 32'h33);
    cmd_ready = 1; wr(CA, 32'h34); cmd_ready = 0;
    chk("R7 drop with pop", q.size() == 3, 128'(q.size()), 3);

    tag = "R6";
    for (int i = 0; i < 12; i++) begin
      cmd_ready = (i % 3) != 1;
      tick();
    end
    cmd_ready = 0;
    chk("R6 drained", cmd_valid == 0, 128'(cmd_valid), 0);
    chk("R7 sticky", overflow == 1, 128'(overflow), 1);

    tag = "R9";
    rst = 1; tick(); rst = 0; tick();
    chk("R9 overflow cleared", overflow == 0, 128'(overflow), 0);
    cmd(32'h4000_0000);
    chk("R9 phase cleared", cmd_y == 32'h4000_0000, 128'(cmd_y), 128'(32'h4000_0000));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule